// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block models a single-ported synchronous SRAM that can run short bursts. Every control and data input is registered on the rising clock edge. Reads leave through a second register, so the first word of an access appears two edges after the edge that captured it. Two independent active-low address strobes exist, one intended for a processor and one for a memory controller. Either strobe loads a new base address and a chip-select decision. After that, an active-low advance input walks a 2-bit counter through the four words of an aligned group. A mode input chooses the walk order: linear wrap-around or exclusive-or (interleaved).

Each access is either a read or a write. A write takes the data that was captured on the same edge as its controls. A global write-enable writes all four 9-bit lanes of the 36-bit word. When the global enable is not asserted, a byte-write enable writes only the lanes selected by their own active-low lane enables. Three chip selects qualify a strobe. If any one of them is inactive, the access sequence stops and the data outputs turn off. Output enable works without the clock and gates only the tri-state control of the read data.

Top module: `burst_sram`

## Requirements
- R1: The word address of an access is {base[ADDR_W-1:2], off}. Here off = base[1:0] + count (mod 4) when the order latched at the strobe is linear (`interleave`=0), and off = base[1:0] XOR count when it is interleaved (`interleave`=1).
- R2: Address, order and chip-select decision are loaded only on an edge where `cpu_strb_n` or `ctl_strb_n` is low. On other edges, a change on `addr` or the chip selects has no effect.
- R3: On an edge with no strobe, `adv_n` low increments the count by one with wrap from 3 to 0. `adv_n` high keeps the count, so the same word is accessed again.
- R4: When `glob_we_n` is low at an access, all four lanes are written with `wdata`, whatever the values of `byte_we_n` and `lane_we_n`.
- R5: When `glob_we_n` is high and `byte_we_n` is low, lane i (bits 9i+8 down to 9i) is written only if `lane_we_n[i]` is low, and the other lanes keep their contents. When both enables are high, the access is a read.
- R6: Read data captured at edge k drives `rdata` with `rdata_en` high after edge k+2. A burst started at edge k with advance at edges k+1, k+2 and k+3 therefore gives words after edges k+2, k+3, k+4 and k+5 (3-1-1-1).
- R7: A strobe while `cs0_n` is high, `cs1` is low or `cs2_n` is high stops all accesses. No write takes place, and `rdata_en` is low from edge k+2 until the next selected strobe.
- R8: `rdata_en` equals the internal output-valid bit AND NOT `oe_n`, with no clock involved. Raising `oe_n` clears it at once.
- R9: A strobe in the middle of a burst reloads the base address and restarts the count at zero on that edge.
- R10: While `rst_n` is low at an edge, the next cycle shows `rdata_en` low and no burst is active.
- R11: An access that writes any lane produces no read, so `rdata_en` is low in that access's output slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, loaded on a strobe |
| cpu_strb_n | input | 1 | Processor-side address strobe, active low |
| ctl_strb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| interleave | input | 1 | Burst order at a strobe: 1 interleaved, 0 linear |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| byte_we_n | input | 1 | Byte-write enable, active low |
| glob_we_n | input | 1 | Global write, active low, overrides lane enables |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_en | output | 1 | Tri-state enable for `rdata` |

## Verification
The bench targets the wrap of the 2-bit count from start offsets 2 and 3 in both orders. A swapped or mis-masked order would return data from a neighbouring word of the group. It drives global writes with every lane enable high, and byte writes with mixed lane masks. An override that lost priority, or a wrong lane-to-bit mapping, leaves stale or corrupted lanes in later reads. It also covers a strobe that restarts a burst in its middle, an address that changes without a strobe, and each chip select turned off in turn. An early or late output register, a counter that does not restart, or a deselect that still lets a stray word or write through all show up as mismatches. Toggling output enable between clock edges catches an enable that was wrongly registered.

// File: rtl/bsram_pkg.sv
// Package: shared burst constants, order type and the offset function.
// Assumes a burst covers exactly four words (2-bit counter).
package bsram_pkg;

    localparam int unsigned BURST_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Low address bits for a given start offset, step count and order.
    function automatic logic [BURST_W-1:0] burst_offset(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input burst_order_e       ord
    );
        if (ord == ORD_INTERLEAVE) begin
            return start ^ step;
        end
        return start + step;
    endfunction

endpackage

// File: rtl/bsram_in_reg.sv
// Module: input capture stage. Registers every synchronous input on the
// rising edge and converts active-low pins to active-high internal flags.
// Assumes: control flags reset synchronously, data/address need no reset.
module bsram_in_reg
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                cpu_strb_n_i,
    input  logic                ctl_strb_n_i,
    input  logic                adv_n_i,
    input  logic                cs0_n_i,
    input  logic                cs1_i,
    input  logic                cs2_n_i,
    input  logic                interleave_i,
    input  logic [LANES-1:0]    lane_we_n_i,
    input  logic                byte_we_n_i,
    input  logic                glob_we_n_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic                ld_o,
    output logic                sel_o,
    output logic                adv_o,
    output burst_order_e        order_o,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [LANES-1:0]    lane_sel_o,
    output logic                byte_wr_o,
    output logic                all_wr_o,
    output logic [DATA_W-1:0]   wdata_o
);

    // Purpose: capture control flags, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_o       <= 1'b0;
            sel_o      <= 1'b0;
            adv_o      <= 1'b0;
            byte_wr_o  <= 1'b0;
            all_wr_o   <= 1'b0;
            lane_sel_o <= '0;
            order_o    <= ORD_LINEAR;
        end else begin
            ld_o       <= !cpu_strb_n_i || !ctl_strb_n_i;
            sel_o      <= !cs0_n_i && cs1_i && !cs2_n_i;
            adv_o      <= !adv_n_i;
            byte_wr_o  <= !byte_we_n_i;
            all_wr_o   <= !glob_we_n_i;
            lane_sel_o <= ~lane_we_n_i;
            order_o    <= interleave_i ? ORD_INTERLEAVE : ORD_LINEAR;
        end
    end

    // Purpose: capture address and write data every edge.
    always_ff @(posedge clk) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
    end

endmodule

// File: rtl/bsram_burst_ctl.sv
// Module: burst address generator. Holds the base address, 2-bit count,
// latched order and active flag; produces the address of the access that
// runs in the current cycle from the freshly captured controls.
// Assumes ADDR_W is larger than the burst counter width.
module bsram_burst_ctl
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic              sel_i,
    input  logic              adv_i,
    input  burst_order_e      order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic              acc_en_o
);

    logic [ADDR_W-1:0]  base_r, base_nxt;
    logic [BURST_W-1:0] cnt_r, cnt_nxt;
    burst_order_e       ord_r, ord_nxt;
    logic               act_r, act_nxt;
    logic [BURST_W-1:0] off;

    // Purpose: choose reload, step or hold for the burst state.
    always_comb begin
        if (ld_i) begin
            base_nxt = addr_i;
            cnt_nxt  = '0;
            ord_nxt  = order_i;
            act_nxt  = sel_i;
        end else begin
            base_nxt = base_r;
            ord_nxt  = ord_r;
            act_nxt  = act_r;
            cnt_nxt  = adv_i ? cnt_r + 2'd1 : cnt_r;
        end
    end

    // Purpose: form the access address from base and ordered offset.
    always_comb begin
        off        = burst_offset(base_nxt[BURST_W-1:0], cnt_nxt, ord_nxt);
        acc_addr_o = {base_nxt[ADDR_W-1:BURST_W], off};
        acc_en_o   = act_nxt;
    end

    // Purpose: keep the burst state between accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_r <= '0;
            cnt_r  <= '0;
            ord_r  <= ORD_LINEAR;
            act_r  <= 1'b0;
        end else begin
            base_r <= base_nxt;
            cnt_r  <= cnt_nxt;
            ord_r  <= ord_nxt;
            act_r  <= act_nxt;
        end
    end

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (cnt_r == '0) && (base_r == $past(addr_i)));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && adv_i) |=> cnt_r == $past(cnt_r) + 2'd1);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && !adv_i) |=> $stable(cnt_r));
    p_noload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> $stable(base_r) && $stable(act_r));
    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !act_r);

endmodule

// File: rtl/bsram_lane_dec.sv
// Module: lane write decoder. Global write selects every lane; otherwise
// the byte-write enable passes the individual lane selects through.
// Assumes all inputs are already registered and active high.
module bsram_lane_dec #(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             all_wr_i,
    input  logic             byte_wr_i,
    input  logic [LANES-1:0] lane_sel_i,
    output logic [LANES-1:0] lane_wr_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Purpose: write strobe of one lane.
        always_comb begin
            lane_wr_o[g] = en_i && (all_wr_i || (byte_wr_i && lane_sel_i[g]));
        end
    end

    p_global_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && all_wr_i) |-> (&lane_wr_o));
    p_no_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_wr_i && !byte_wr_i) |-> (lane_wr_o == '0));
    p_desel_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (lane_wr_o == '0));

endmodule

// File: rtl/bsram_array.sv
// Module: storage array split into lanes, with a registered read port.
// A cycle that writes any lane does not produce a read.
// Assumes contents are undefined until written (no reset on storage).
module bsram_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned DATA_W = LANES * LANE_W,
    localparam int unsigned DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [LANES-1:0]  lane_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_vld_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q;

        // Purpose: write this lane and read it into the lane register.
        always_ff @(posedge clk) begin
            if (lane_wr_i[g]) begin
                mem[acc_addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
            q <= mem[acc_addr_i];
        end

        assign rd_data_o[g*LANE_W +: LANE_W] = q;
    end

    // Purpose: flag a real read access in the data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld_o <= 1'b0;
        end else begin
            rd_vld_o <= acc_en_i && (lane_wr_i == '0);
        end
    end

    p_wr_no_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wr_i != '0) |=> !rd_vld_o);
    p_desel_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en_i |=> !rd_vld_o);

endmodule

// File: rtl/bsram_out_stage.sv
// Module: output register plus asynchronous output-enable gating.
// Assumes oe_n may change at any time relative to the clock.
module bsram_out_stage #(
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              rd_vld_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_en_o
);

    logic out_vld;

    // Purpose: valid bit of the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= rd_vld_i;
        end
    end

    // Purpose: output data register.
    always_ff @(posedge clk) begin
        dout_o <= rd_data_i;
    end

    // Purpose: clock-free gating of the tri-state enable.
    always_comb begin
        dout_en_o = out_vld && !oe_n_i;
    end

    p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !dout_en_o);
    p_pipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld_i |=> dout_o == $past(rd_data_i));
    p_reset_out_r10: assert property (@(posedge clk)
        !rst_n |=> !dout_en_o);

endmodule

// File: rtl/burst_sram.sv
// Module: top of the pipelined burst SRAM model. Input registers feed the
// burst generator and lane decoder; the array read register and the output
// register give two edges from capture to data.
// Assumes a single clock and synchronous active-low reset.
module burst_sram #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cpu_strb_n,
    input  logic              ctl_strb_n,
    input  logic              adv_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              cs2_n,
    input  logic              interleave,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              byte_we_n,
    input  logic              glob_we_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_en
);

    import bsram_pkg::*;

    logic              ld_q, sel_q, adv_q, byte_wr_q, all_wr_q;
    burst_order_e      order_q;
    logic [ADDR_W-1:0] addr_q, acc_addr;
    logic [LANES-1:0]  lane_sel_q, lane_wr;
    logic [DATA_W-1:0] wdata_q, rd_data;
    logic              acc_en, rd_vld;

    bsram_in_reg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
        .clk(clk), .rst_n(rst_n), .addr_i(addr),
        .cpu_strb_n_i(cpu_strb_n), .ctl_strb_n_i(ctl_strb_n), .adv_n_i(adv_n),
        .cs0_n_i(cs0_n), .cs1_i(cs1), .cs2_n_i(cs2_n),
        .interleave_i(interleave), .lane_we_n_i(lane_we_n),
        .byte_we_n_i(byte_we_n), .glob_we_n_i(glob_we_n), .wdata_i(wdata),
        .ld_o(ld_q), .sel_o(sel_q), .adv_o(adv_q), .order_o(order_q),
        .addr_o(addr_q), .lane_sel_o(lane_sel_q), .byte_wr_o(byte_wr_q),
        .all_wr_o(all_wr_q), .wdata_o(wdata_q)
    );

    bsram_burst_ctl #(.ADDR_W(ADDR_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .ld_i(ld_q), .sel_i(sel_q), .adv_i(adv_q),
        .order_i(order_q), .addr_i(addr_q),
        .acc_addr_o(acc_addr), .acc_en_o(acc_en)
    );

    bsram_lane_dec #(.LANES(LANES)) u_dec (
        .clk(clk), .rst_n(rst_n), .en_i(acc_en), .all_wr_i(all_wr_q),
        .byte_wr_i(byte_wr_q), .lane_sel_i(lane_sel_q), .lane_wr_o(lane_wr)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .acc_en_i(acc_en), .acc_addr_i(acc_addr),
        .lane_wr_i(lane_wr), .wdata_i(wdata_q),
        .rd_data_o(rd_data), .rd_vld_o(rd_vld)
    );

    bsram_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .rd_data_i(rd_data), .rd_vld_i(rd_vld),
        .oe_n_i(oe_n), .dout_o(rdata), .dout_en_o(rdata_en)
    );

endmodule

// File: tb/tb_burst_sram.sv
// Bench: fixed-seed random traffic plus directed corner cases, checked
// every cycle against a bench-side burst model and associative memory.
module tb_burst_sram;

    localparam int AW = 8;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cpu_strb_n = 1'b1, ctl_strb_n = 1'b1, adv_n = 1'b1;
    logic          cs0_n = 1'b0, cs1 = 1'b1, cs2_n = 1'b0, interleave = 1'b0;
    logic [LN-1:0] lane_we_n = '1;
    logic          byte_we_n = 1'b1, glob_we_n = 1'b1, oe_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_en;

    burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strb_n(cpu_strb_n),
        .ctl_strb_n(ctl_strb_n), .adv_n(adv_n), .cs0_n(cs0_n), .cs1(cs1),
        .cs2_n(cs2_n), .interleave(interleave), .lane_we_n(lane_we_n),
        .byte_we_n(byte_we_n), .glob_we_n(glob_we_n), .wdata(wdata),
        .oe_n(oe_n), .rdata(rdata), .rdata_en(rdata_en)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    string tag = "R10";

    logic [DW-1:0] ref_mem [int];
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic          m_act = 1'b0, m_ord = 1'b0;
    logic          p0_v = 1'b0, p1_v = 1'b0, o_v = 1'b0;
    logic [DW-1:0] p0_d = '0, p1_d = '0, o_d = '0;

    function automatic logic [DW-1:0] rnd_word();
        logic [63:0] t = {$urandom(), $urandom()};
        return t[DW-1:0];
    endfunction

    function automatic logic [AW-1:0] acc_addr(input logic [AW-1:0] b,
            input logic [1:0] c, input logic ord);
        logic [1:0] off = ord ? (b[1:0] ^ c) : (b[1:0] + c);
        return {b[AW-1:2], off};
    endfunction

    task automatic check(input logic got_en, input logic exp_en,
                         input logic [DW-1:0] got_d, input logic [DW-1:0] exp_d);
        checks++;
        if (got_en !== exp_en || (exp_en && got_d !== exp_d)) begin
            fails++;
            $display("FAIL %s: rdata_en=%0b rdata=%h expected rdata_en=%0b rdata=%h",
                     tag, got_en, got_d, exp_en, exp_d);
        end
    endtask

    task automatic idle();
        cpu_strb_n = 1'b1; ctl_strb_n = 1'b1; adv_n = 1'b1;
        glob_we_n = 1'b1; byte_we_n = 1'b1; lane_we_n = '1;
    endtask

    // One clock: inputs are already driven; model the access, then check.
    task automatic tick();
        logic [AW-1:0] a;
        logic [LN-1:0] m;
        @(posedge clk);
        o_v = p1_v; o_d = p1_d; p1_v = p0_v; p1_d = p0_d; p0_v = 1'b0;
        if (!cpu_strb_n || !ctl_strb_n) begin
            m_base = addr; m_cnt = '0; m_ord = interleave;
            m_act = !cs0_n && cs1 && !cs2_n;
        end else if (!adv_n) begin
            m_cnt = m_cnt + 2'd1;
        end
        if (m_act) begin
            a = acc_addr(m_base, m_cnt, m_ord);
            m = !glob_we_n ? '1 : (!byte_we_n ? ~lane_we_n : '0);
            if (m != '0) begin
                logic [DW-1:0] w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
                for (int i = 0; i < LN; i++)
                    if (m[i]) w[i*LW +: LW] = wdata[i*LW +: LW];
                ref_mem[int'(a)] = w;
            end else begin
                p0_v = 1'b1;
                p0_d = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
            end
        end
        @(negedge clk);
        check(rdata_en, o_v && !oe_n, rdata, o_d);
    endtask

    task automatic strobe(input logic [AW-1:0] a, input logic ord, input logic use_cpu);
        idle();
        addr = a; interleave = ord;
        if (use_cpu) cpu_strb_n = 1'b0; else ctl_strb_n = 1'b0;
        tick();
        idle();
    endtask

    task automatic advance(input int n);
        for (int i = 0; i < n; i++) begin
            idle(); adv_n = 1'b0; tick();
        end
        idle();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        // R10: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        tag = "R10";
        check(rdata_en, 1'b0, rdata, '0);
        rst_n = 1'b1;
        tick();
        check(rdata_en, 1'b0, rdata, '0);

        // R4: fill the array with global writes, lane enables all high
        tag = "R4";
        for (int b = 0; b < (1 << AW) / 4; b++) begin
            idle(); addr = AW'(b * 4); interleave = 1'b0;
            if (b % 2 == 0) ctl_strb_n = 1'b0; else cpu_strb_n = 1'b0;
            glob_we_n = 1'b0; byte_we_n = b[0]; wdata = rnd_word(); tick();
            for (int k = 0; k < 3; k++) begin
                idle(); adv_n = 1'b0; glob_we_n = 1'b0; wdata = rnd_word(); tick();
            end
        end
        idle(); tick(); tick();

        // R6, R1: linear burst from offset 2 (wrap), 3-1-1-1 timing
        tag = "R6 R1 linear";
        strobe(8'h12, 1'b0, 1'b1); advance(3); tick(); tick();
        // R1: interleaved burst from offset 3
        tag = "R1 interleaved";
        strobe(8'h27, 1'b1, 1'b0); advance(3); tick(); tick();

        // R5: byte write lanes 0 and 2 only, then read back
        tag = "R5";
        idle(); addr = 8'h31; ctl_strb_n = 1'b0; byte_we_n = 1'b0;
        lane_we_n = 4'b1010; wdata = rnd_word(); tick();
        idle(); adv_n = 1'b0; byte_we_n = 1'b0; lane_we_n = 4'b0111;
        wdata = rnd_word(); tick();
        idle(); adv_n = 1'b0; lane_we_n = 4'b0000; wdata = rnd_word(); tick();
        strobe(8'h31, 1'b0, 1'b1); advance(2); tick(); tick();

        // R3: hold with advance high repeats the word; R2: address change ignored
        tag = "R3 R2";
        strobe(8'h40, 1'b1, 1'b1);
        addr = 8'h99; cs0_n = 1'b1; tick(); tick(); cs0_n = 1'b0;
        advance(1); idle(); tick(); tick(); tick();

        // R9: restart in the middle of a burst
        tag = "R9";
        strobe(8'h50, 1'b0, 1'b0); advance(1);
        strobe(8'h66, 1'b1, 1'b1); advance(3); tick(); tick();

        // R7: each chip select inactive at a strobe
        tag = "R7";
        for (int c = 0; c < 3; c++) begin
            strobe(8'h70, 1'b0, 1'b1); advance(1);
            cs0_n = (c == 0); cs1 = (c != 1); cs2_n = (c == 2);
            idle(); addr = 8'h74; cpu_strb_n = 1'b0; glob_we_n = 1'b0;
            wdata = rnd_word(); tick();
            cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
            advance(2); tick(); tick();
            strobe(8'h74, 1'b0, 1'b0); tick(); tick();
        end

        // R8: output enable acts between clock edges
        tag = "R8";
        strobe(8'h84, 1'b0, 1'b1); advance(2);
        #2 oe_n = 1'b1; #1;
        check(rdata_en, 1'b0, rdata, o_d);
        oe_n = 1'b0; #1;
        check(rdata_en, o_v, rdata, o_d);
        tick(); tick();

        // R11: write cycle leaves its output slot empty
        tag = "R11";
        strobe(8'h90, 1'b0, 1'b1);
        idle(); adv_n = 1'b0; glob_we_n = 1'b0; wdata = rnd_word(); tick();
        idle(); tick(); tick();

        // Random traffic covering all requirements
        tag = "R1 R2 R3 R4 R5 R6 R7 R8 R9 R11 random";
        for (int n = 0; n < 2500; n++) begin
            int r = $urandom_range(99);
            idle();
            addr = AW'($urandom());
            wdata = rnd_word();
            if (r < 20) begin
                if ($urandom_range(1) == 0) cpu_strb_n = 1'b0; else ctl_strb_n = 1'b0;
                interleave = $urandom_range(1) == 1;
                cs0_n = $urandom_range(19) == 0;
                cs1   = $urandom_range(19) != 0;
                cs2_n = $urandom_range(19) == 0;
            end
            adv_n = $urandom_range(9) < 4;
            r = $urandom_range(99);
            if (r < 12) glob_we_n = 1'b0;
            if (r >= 6 && r < 35) begin
                byte_we_n = 1'b0; lane_we_n = LN'($urandom());
            end
            oe_n = $urandom_range(9) == 0;
            tick();
        end
        idle(); oe_n = 1'b0; cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
        tick(); tick();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule